// File: doc/BRIEF.md
# Video Output Control Word and Buffer Handshake

This block is the control and status register pair of a video output engine. The control word holds the engine's operating mode, clock source choice, two divider ratios, pin-direction bits, the frame-reference edge polarity, the overlay switch and a power-management override. Beside it sits an enable register. That register carries the run bit, four interrupt enables and a read-only view of four status flags: buffer 1 empty, buffer 2 empty, horizontal-blank error and underrun.

Software arms the transfer buffers with write-one acknowledge bits, which are never stored. The datapath raises the flags again with single-cycle set pulses. A software reset bit holds the engine idle but leaves the configuration intact. Only the hardware reset returns the word to its default, which makes every pin an input. After a software reset is released, a short settle window must pass before the run bit can be set.

Top module: `vo_ctrl_reg`

## Requirements
- R1: After hardware reset, the control word (`addr`=0) reads 0x32400000: clock select [29:28]=3, input divider [27:25]=1, feedback divider [24:22]=1, all else 0. The enable register (`addr`=1) reads 0x00000C00, with both buffers empty and no error, no enable and no interrupt enable. `vclk_oe`, `io1_oe` and `io2_oe` are 0.
- R2: A write to `addr`=0 stores bits 31:17 and 7:4 of `wr_data`. The field layout is: [31] soft reset, [30] sleepless, [29:28] clock select, [27:25] input divider, [24:22] feedback divider, [21] clock out, [20] sync master, [19] pin-1 polarity, [18] pin-2 polarity, [17] overlay, [7:4] mode. A read returns bit 31, bits 16:8 and the acknowledge bits 3:0 as 0. The stored fields drive `clk_sel`, `div_in`, `div_fb`, `overlay_en` and `mode`.
- R3: While control bit 31 is 1, `engine_rst` is 1, `engine_en` is 0 from the next cycle on, and both empty flags are held at 1. The other fields keep the values written.
- R4: After the write that clears bit 31, enable writes sampled at the next 5 clock edges are ignored. Writes from the 6th edge on are honoured.
- R5: Control bits 3 and 2 acknowledge buffer 1 and buffer 2. Writing 1 clears that buffer's empty flag, and writing 0 has no effect. They act only in message mode (mode 2) for buffer 1, and in streaming mode (mode 3) for both buffers. In any other mode they are ignored.
- R6: An accepted enable write with bit 0 = 1 also acknowledges both buffers in mode 3 and only buffer 1 in mode 2. The buffer 2 acknowledge has no effect in mode 2.
- R7: `bfr_go[1]` (buffer 1) and `bfr_go[0]` (buffer 2) are high while the engine is enabled and the buffer's empty flag is 0. A `set_bfr_empty` pulse sets the flag again.
- R8: Control bits 1 and 0 clear the horizontal-blank error and underrun flags, which `set_hbe` and `set_urun` raise. A set and an acknowledge in the same cycle leave the flag at 1.
- R9: `irq` is the OR of the four flags, each ANDed with its enable bit. The enable register layout is: [0] run, [4] buffer 1, [3] buffer 2, [2] blank error, [1] underrun. The flags read back at [11] buffer 1 empty, [10] buffer 2 empty, [9] blank error, [8] underrun.
- R10: `vclk_oe` follows control bit 21, and `io1_oe` and `io2_oe` follow bit 20.
- R11: When bit 20 is 0, `frame_evt` pulses on a rising edge of `io2_in` if bit 18 is 1, and on a falling edge if bit 18 is 0. When bit 20 is 1 it stays 0.
- R12: `pwr_dn_ack` follows `pwr_dn_req` unless bit 30 is 1, in which case it is 0.
- R13: A write to `addr`=1 stores the interrupt enables. Writing bit 0 as 0 clears `engine_en`, which rises only on an accepted enable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = control word, 1 = enable register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| set_bfr_empty | input | 2 | [1] buffer 1, [0] buffer 2 drained |
| set_hbe | input | 1 | Horizontal-blank error pulse |
| set_urun | input | 1 | Underrun pulse |
| io2_in | input | 1 | Frame reference pin input |
| pwr_dn_req | input | 1 | Global power-down request |
| engine_rst | output | 1 | Engine held in software reset |
| engine_en | output | 1 | Engine running |
| bfr_go | output | 2 | Buffer transfer enables |
| irq | output | 1 | Interrupt |
| clk_sel | output | 2 | Clock source select |
| div_in | output | 3 | Input divider ratio code |
| div_fb | output | 3 | Feedback divider ratio code |
| vclk_oe | output | 1 | Drive the video clock pin |
| io1_oe | output | 1 | Drive sync pin 1 |
| io2_oe | output | 1 | Drive sync pin 2 |
| frame_evt | output | 1 | Active frame-reference edge seen |
| overlay_en | output | 1 | Overlay enable |
| mode | output | 4 | Operating mode |
| pwr_dn_ack | output | 1 | Power-down granted |

## Verification
The assertions assume that `set_hbe`, `set_urun` and `set_bfr_empty` are synchronous to `clk` and never X after reset. They also assume that `io2_in` is already synchronised. The bench drives every input half a period away from the sampling edge and keeps `io2_in` low through hardware reset. In its random phase it holds the mode field to codes 0 to 3 so that both buffer-handshake modes occur often. It sets the soft reset bit only rarely, so that enabled stretches last long enough for the flags to cycle.

// File: rtl/vo_ctrl_reg.sv
module vo_ctrl_reg #(
  parameter int SETTLE_CYC = 5,
  parameter logic [3:0] MODE_MSG = 4'h2,
  parameter logic [3:0] MODE_STREAM = 4'h3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic [1:0]  set_bfr_empty,
  input  logic        set_hbe,
  input  logic        set_urun,
  input  logic        io2_in,
  input  logic        pwr_dn_req,
  output logic        engine_rst,
  output logic        engine_en,
  output logic [1:0]  bfr_go,
  output logic        irq,
  output logic [1:0]  clk_sel,
  output logic [2:0]  div_in,
  output logic [2:0]  div_fb,
  output logic        vclk_oe,
  output logic        io1_oe,
  output logic        io2_oe,
  output logic        frame_evt,
  output logic        overlay_en,
  output logic [3:0]  mode,
  output logic        pwr_dn_ack
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] SETTLED = CW'(SETTLE_CYC);
  localparam logic [31:0] HW_DEFAULT = 32'h3240_0000;
  localparam logic [31:0] STORE_MASK = 32'hFFFE_00F0;
  localparam logic [31:0] READ_MASK  = 32'h7FFE_00F0;

  logic [31:0]   ctl_q;
  logic [3:0]    ie_q;
  logic [1:0]    empty_q;
  logic          hbe_q, urun_q, en_q, io2_q;
  logic [CW-1:0] cnt_q;

  wire ctl_wr   = wr_en & ~addr;
  wire en_wr    = wr_en & addr;
  wire soft_rst = ctl_q[31];
  wire settled  = (cnt_q == SETTLED);
  wire is_msg   = (mode == MODE_MSG);
  wire is_strm  = (mode == MODE_STREAM);
  wire [3:0] ack = ctl_wr ? wr_data[3:0] : 4'b0;
  wire go       = en_wr & wr_data[0] & ~soft_rst & settled;
  wire ack_b1   = (ack[3] | go) & (is_msg | is_strm);
  wire ack_b2   = (ack[2] | go) & is_strm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= HW_DEFAULT;
      ie_q    <= '0;
      empty_q <= 2'b11;
      hbe_q   <= 1'b0;
      urun_q  <= 1'b0;
      en_q    <= 1'b0;
      io2_q   <= 1'b0;
      cnt_q   <= SETTLED;
    end else begin
      if (ctl_wr) ctl_q <= wr_data & STORE_MASK;
      if (en_wr) ie_q <= wr_data[4:1];
      empty_q[1] <= soft_rst | set_bfr_empty[1] | (empty_q[1] & ~ack_b1);
      empty_q[0] <= soft_rst | set_bfr_empty[0] | (empty_q[0] & ~ack_b2);
      hbe_q  <= set_hbe  | (hbe_q  & ~ack[1]);
      urun_q <= set_urun | (urun_q & ~ack[0]);
      if (soft_rst) en_q <= 1'b0;
      else if (en_wr && !wr_data[0]) en_q <= 1'b0;
      else if (go) en_q <= 1'b1;
      if (soft_rst) cnt_q <= '0;
      else if (!settled) cnt_q <= cnt_q + 1'b1;
      io2_q <= io2_in;
    end
  end

  assign engine_rst = soft_rst;
  assign engine_en  = en_q;
  assign bfr_go     = {2{en_q}} & ~empty_q;
  assign irq        = |({empty_q, hbe_q, urun_q} & ie_q);
  assign clk_sel    = ctl_q[29:28];
  assign div_in     = ctl_q[27:25];
  assign div_fb     = ctl_q[24:22];
  assign vclk_oe    = ctl_q[21];
  assign io1_oe     = ctl_q[20];
  assign io2_oe     = ctl_q[20];
  assign overlay_en = ctl_q[17];
  assign mode       = ctl_q[7:4];
  assign pwr_dn_ack = pwr_dn_req & ~ctl_q[30];
  assign frame_evt  = ~ctl_q[20] & (ctl_q[18] ? (io2_in & ~io2_q) : (~io2_in & io2_q));
  assign rd_data    = addr ? {20'b0, empty_q, hbe_q, urun_q, 3'b0, ie_q, en_q}
                           : (ctl_q & READ_MASK);
endmodule

module vo_ctrl_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        addr,
  input logic [31:0] wr_data,
  input logic [1:0]  set_bfr_empty,
  input logic        set_hbe,
  input logic        set_urun,
  input logic        engine_rst,
  input logic        engine_en,
  input logic [1:0]  bfr_go,
  input logic        irq,
  input logic [1:0]  empty_q,
  input logic        hbe_q,
  input logic        urun_q
);
  // R8
  hbe_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_hbe |=> hbe_q);
  // R8
  urun_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wr_data[0] && !set_urun) |=> !urun_q);
  // R13
  en_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(engine_en) |-> $past(wr_en && addr && wr_data[0]));
  // R3
  soft_rst_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    engine_rst |=> !engine_en);
  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (empty_q != 2'b00 || hbe_q || urun_q));
  // R7
  drained_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_bfr_empty[1] |=> !bfr_go[1]);
endmodule

bind vo_ctrl_reg vo_ctrl_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .set_bfr_empty(set_bfr_empty), .set_hbe(set_hbe), .set_urun(set_urun),
  .engine_rst(engine_rst), .engine_en(engine_en), .bfr_go(bfr_go), .irq(irq),
  .empty_q(empty_q), .hbe_q(hbe_q), .urun_q(urun_q)
);

// File: tb/tb_vo_ctrl_reg.sv
module tb_vo_ctrl_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, addr = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0] set_bfr_empty = '0;
  logic set_hbe = 1'b0, set_urun = 1'b0, io2_in = 1'b0, pwr_dn_req = 1'b0;
  logic [31:0] rd_data;
  logic engine_rst, engine_en, irq, vclk_oe, io1_oe, io2_oe, frame_evt, overlay_en, pwr_dn_ack;
  logic [1:0] bfr_go, clk_sel;
  logic [2:0] div_in, div_fb;
  logic [3:0] mode;

  int checks = 0, errors = 0;

  vo_ctrl_reg dut (.*);

  always #4 clk = ~clk;

  // behavioural reference state
  bit [31:0] m_ctl;
  bit [3:0]  m_ie;
  bit m_e1, m_e2, m_hbe, m_urun, m_en, m_io2q;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctl = 32'h3240_0000; m_ie = 0; m_e1 = 1; m_e2 = 1;
      m_hbe = 0; m_urun = 0; m_en = 0; m_io2q = 0; m_cnt = 5;
    end else begin
      bit sr, strm, msg, go, a1, a2;
      bit [3:0] ack;
      sr   = m_ctl[31];
      strm = (m_ctl[7:4] == 3);
      msg  = (m_ctl[7:4] == 2);
      ack  = (wr_en && !addr) ? wr_data[3:0] : 4'd0;
      go   = wr_en && addr && wr_data[0] && !sr && (m_cnt >= 5);
      a1   = (ack[3] || go) && (strm || msg);
      a2   = (ack[2] || go) && strm;
      if (sr) m_en = 0;
      else if (wr_en && addr && !wr_data[0]) m_en = 0;
      else if (go) m_en = 1;
      if (sr) m_cnt = 0; else if (m_cnt < 5) m_cnt++;
      m_e1   = sr || set_bfr_empty[1] || (m_e1 && !a1);
      m_e2   = sr || set_bfr_empty[0] || (m_e2 && !a2);
      m_hbe  = set_hbe  || (m_hbe  && !ack[1]);
      m_urun = set_urun || (m_urun && !ack[0]);
      if (wr_en && addr) m_ie = wr_data[4:1];
      if (wr_en && !addr) m_ctl = wr_data & 32'hFFFE_00F0;
      m_io2q = io2_in;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit [31:0] erd;
      bit efr;
      erd = addr ? {20'd0, m_e1, m_e2, m_hbe, m_urun, 3'd0, m_ie, m_en}
                 : {1'b0, m_ctl[30:17], 9'd0, m_ctl[7:4], 4'd0};
      efr = !m_ctl[20] && (m_ctl[18] ? (io2_in && !m_io2q) : (!io2_in && m_io2q));
      chk(addr ? "R13 read" : "R2 read", rd_data, erd);
      chk("R3 engine_rst", 32'(engine_rst), 32'(m_ctl[31]));
      chk("R4 engine_en", 32'(engine_en), 32'(m_en));
      chk("R7 bfr_go", 32'(bfr_go), 32'({m_en && !m_e1, m_en && !m_e2}));
      chk("R9 irq", 32'(irq), 32'((m_e1 && m_ie[3]) || (m_e2 && m_ie[2]) || (m_hbe && m_ie[1]) || (m_urun && m_ie[0])));
      chk("R2 fields", {18'd0, clk_sel, div_in, div_fb, overlay_en, mode},
          {18'd0, m_ctl[29:28], m_ctl[27:25], m_ctl[24:22], m_ctl[17], m_ctl[7:4]});
      chk("R10 pins", {29'd0, vclk_oe, io1_oe, io2_oe}, {29'd0, m_ctl[21], m_ctl[20], m_ctl[20]});
      chk("R11 frame_evt", 32'(frame_evt), 32'(efr));
      chk("R12 pwr_dn_ack", 32'(pwr_dn_ack), 32'(pwr_dn_req && !m_ctl[30]));
    end
  end

  task automatic cyc(); @(negedge clk); #1; endtask
  task automatic wr(logic a, logic [31:0] d);
    wr_en = 1; addr = a; wr_data = d; cyc(); wr_en = 0; wr_data = 0;
  endtask
  task automatic peek(logic a, string req, logic [31:0] exp);
    addr = a; #1; chk(req, rd_data, exp);
  endtask
  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  localparam logic [31:0] CFG = 32'h6766_0030;

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    peek(0, "R1 control default", 32'h3240_0000);
    chk("R1 pins input", {vclk_oe, io1_oe, io2_oe}, 0);
    peek(1, "R1 enable default", 32'h0000_0C00);
    chk("R1 irq", 32'(irq), 0);

    wr(0, 32'hFFFF_FFFF);
    peek(0, "R2 masked readback", 32'h7FFE_00F0);
    chk("R3 held", 32'(engine_rst), 1);
    wr(0, CFG | 32'h3);                               // release edge B
    peek(0, "R2 config", CFG);
    chk("R3 released", 32'(engine_rst), 0);
    wr(1, 32'h1F);                                    // B+1 ignored
    peek(1, "R4 early enable", 32'h0000_0C1E);
    cyc(); cyc(); cyc();
    wr(1, 32'h1F);                                    // B+5 ignored
    chk("R4 fifth edge", 32'(engine_en), 0);
    wr(1, 32'h1F);                                    // B+6 accepted
    chk("R4 accepted", 32'(engine_en), 1);
    peek(1, "R6 stream acks both", 32'h0000_001F);
    chk("R7 both go", 32'(bfr_go), 2'b11);

    set_bfr_empty = 2'b01; cyc(); set_bfr_empty = 0;
    peek(1, "R7 buffer2 drained", 32'h0000_041F);
    chk("R9 irq on empty", 32'(irq), 1);
    wr(0, CFG | 32'h4);
    peek(1, "R5 ack buffer2", 32'h0000_001F);
    wr(0, CFG | 32'h0);
    peek(1, "R5 zero ack", 32'h0000_001F);

    set_hbe = 1; wr_en = 1; addr = 0; wr_data = CFG | 32'h2; cyc();
    wr_en = 0; set_hbe = 0;
    peek(1, "R8 set wins", 32'h0000_021F);
    wr(0, CFG | 32'h2);
    peek(1, "R8 ack clears", 32'h0000_001F);

    set_bfr_empty = 2'b11; cyc(); set_bfr_empty = 0;
    wr(0, 32'h6766_0020);
    wr(1, 32'h1F);
    peek(1, "R6 message acks buffer1", 32'h0000_041F);
    wr(0, 32'h6766_0024);
    peek(1, "R6 buffer2 ack ignored", 32'h0000_041F);

    wr(0, 32'h6766_0000);
    set_bfr_empty = 2'b10; cyc(); set_bfr_empty = 0;
    wr(0, 32'h6766_0008);
    peek(1, "R5 ack ignored in mode 0", 32'h0000_0C1F);

    pwr_dn_req = 1; #1;
    chk("R12 blocked", 32'(pwr_dn_ack), 0);
    wr(0, 32'h2766_0000); #1;
    chk("R12 granted", 32'(pwr_dn_ack), 1);
    pwr_dn_req = 0;
    io2_in = 1; #1;
    chk("R11 rising edge", 32'(frame_evt), 1);
    cyc();
    wr(1, 32'h0);
    chk("R13 run cleared", 32'(engine_en), 0);

    for (int i = 0; i < 1500; i++) begin
      logic [31:0] d;
      d = $urandom;
      d[7:6] = 0;
      if ($urandom_range(15) != 0) d[31] = 0;
      wr_en = ($urandom_range(2) == 0);
      addr = $urandom_range(1);
      wr_data = d;
      set_bfr_empty = ($urandom_range(5) == 0) ? 2'($urandom) : 2'b00;
      set_hbe = ($urandom_range(7) == 0);
      set_urun = ($urandom_range(7) == 0);
      io2_in = $urandom_range(1);
      pwr_dn_req = $urandom_range(1);
      cyc();
    end
    wr_en = 0; set_bfr_empty = 0; set_hbe = 0; set_urun = 0;
    cyc();
    finish_run();
  end
endmodule